// File: doc/BRIEF.md
# Processor data memory with serial-peripheral mailbox

This block is the data store of a small processor, built as a RAM with two ports. The processor owns one port and a serial peripheral controller owns the other. Almost every word is ordinary storage. Two words near the top of the address space work as a one-way mailbox between the processor and the controller.

The processor writes the transfer settings and the byte to send into the configuration word at address 60. The layout of that word is:

- bits [7:0]: byte to transmit
- bit 8: clock polarity
- bit 9: clock phase
- bits [17:10]: clock divider
- bits [20:18]: slave address

That write raises a one-cycle start pulse toward the serial engine. In the same cycle the busy flag of the status word at address 61 is set. The engine reads its settings through its own port. When the transfer ends it writes the received byte and a cleared busy flag into word 61. The processor keeps running meanwhile and polls word 61 until busy drops.

A tiny state machine produces the start pulse. It has two states:

- MB_IDLE: no start pending.
- MB_LAUNCH: the start pulse is asserted.

Its transitions are:

- MB_IDLE to MB_LAUNCH on a configuration write.
- MB_LAUNCH to MB_LAUNCH on another configuration write in the next cycle.
- MB_LAUNCH to MB_IDLE otherwise.

Top module: `spi_mailbox_ram`

## Requirements
- R1: The memory holds 64 words of 32 bits. A processor write to any address other than 61 is stored, and both ports read back the stored word.
- R2: Both ports read synchronously: the word at the address presented in one cycle appears on the read data output after the next rising edge. A read in the same cycle as a write to that address returns the old contents. Both ports may read at once.
- R3: The peripheral port cannot alter word 60. Its writes there are discarded, but it can read the word.
- R4: Peripheral writes to any address other than 61 are discarded.
- R5: Processor writes to address 61 are discarded.
- R6: Word 61 holds the received byte in bits [7:0] and busy in bit 31. A peripheral write to 61 sets both fields from its data, and bits [30:8] always read as zero.
- R7: A processor write to address 60 makes start_pulse high for exactly the cycle after that write's clock edge. Writes in consecutive cycles keep it high in each following cycle.
- R8: Busy in word 61 is set at the same edge at which start_pulse rises. A read of word 61 issued in the cycle after the configuration write returns busy = 1.
- R9: When the peripheral writes word 61 in the same cycle as a processor write to address 60, the received byte comes from the peripheral and busy ends up 1.
- R10: While the active-low reset is asserted, start_pulse is low, the state machine is in MB_IDLE and word 61 is zero. The general storage is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 6 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, one cycle latency |
| per_we | input | 1 | Peripheral write enable |
| per_addr | input | 6 | Peripheral word address |
| per_wdata | input | 32 | Peripheral write data |
| per_rdata | output | 32 | Peripheral read data, one cycle latency |
| start_pulse | output | 1 | One-cycle transfer start toward the serial engine |

## Verification
The bench builds the block with its default parameters: 6 address bits, 32-bit words, and the mailbox at 60 and 61. At that size every address fits in a full sweep. It writes all 64 addresses from each port, computing the expected word arithmetically from the address, and reads every one back through both ports at once. It then steps through the mailbox corner cases one at a time: same-cycle read-before-write, back-to-back starts, the collision between a peripheral status write and a configuration write, and reset applied mid-run.

// File: rtl/spi_mb_pkg.sv
package spi_mb_pkg;

    localparam int RX_W = 8;

    typedef enum logic [0:0] {
        MB_IDLE   = 1'b0,
        MB_LAUNCH = 1'b1
    } mb_state_e;

    // configuration word layout, read by the serial engine
    typedef struct packed {
        logic [10:0] rsvd;
        logic [2:0]  slave_sel;
        logic [7:0]  clk_div;
        logic        phase;
        logic        polarity;
        logic [7:0]  tx_byte;
    } mb_cfg_t;

endpackage

// File: rtl/mb_ctrl.sv
module mb_ctrl
    import spi_mb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    output logic start_pulse
);

    mb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE:   if (cfg_wr) state_d = MB_LAUNCH;
            MB_LAUNCH: state_d = cfg_wr ? MB_LAUNCH : MB_IDLE;
            default:   state_d = MB_IDLE;
        endcase
    end

    always_comb begin
        start_pulse = (state_q == MB_LAUNCH);
    end

    AST_START_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> start_pulse); // R7
    AST_START_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(cfg_wr)); // R7

endmodule

// File: rtl/mb_status.sv
module mb_status
    import spi_mb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_wr,
    input  logic [DATA_W-1:0] per_wdata,
    input  logic              cfg_wr,
    output logic [DATA_W-1:0] stat_word
);

    localparam int BUSY_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << BUSY_BIT) | ((DATA_W'(1) << RX_W) - DATA_W'(1));

    logic [DATA_W-1:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (per_wr)  stat_d = per_wdata & KEEP_MASK;
        if (cfg_wr)  stat_d[BUSY_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_word = stat_q;

    AST_RX_FROM_PER: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> stat_q[RX_W-1:0] == $past(per_wdata[RX_W-1:0])); // R6
    AST_BUSY_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> stat_q[BUSY_BIT]); // R9

endmodule

// File: rtl/mb_array.sv
module mb_array #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int STAT_ADDR = 61
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    input  logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        rd_a_data <= (rd_a_addr == STAT_A) ? stat_word : mem[rd_a_addr];
        rd_b_data <= (rd_b_addr == STAT_A) ? stat_word : mem[rd_b_addr];
    end

endmodule

// File: rtl/spi_mailbox_ram.sv
module spi_mailbox_ram
    import spi_mb_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int CFG_ADDR  = 60,
    parameter int STAT_ADDR = 61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              per_we,
    input  logic [ADDR_W-1:0] per_addr,
    input  logic [DATA_W-1:0] per_wdata,
    output logic [DATA_W-1:0] per_rdata,
    output logic              start_pulse
);

    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic              cfg_wr, per_stat_wr, arr_we;
    logic [DATA_W-1:0] stat_word;

    // processor owns every word except status; peripheral owns only status
    assign cfg_wr      = cpu_we && (cpu_addr == CFG_A);
    assign per_stat_wr = per_we && (per_addr == STAT_A);
    assign arr_we      = cpu_we && (cpu_addr != STAT_A);

    mb_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .start_pulse (start_pulse)
    );

    mb_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_wr    (per_stat_wr),
        .per_wdata (per_wdata),
        .cfg_wr    (cfg_wr),
        .stat_word (stat_word)
    );

    mb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)) u_array (
        .clk       (clk),
        .wr_en     (arr_we),
        .wr_addr   (cpu_addr),
        .wr_data   (cpu_wdata),
        .rd_a_addr (cpu_addr),
        .rd_b_addr (per_addr),
        .stat_word (stat_word),
        .rd_a_data (cpu_rdata),
        .rd_b_data (per_rdata)
    );

    AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> stat_word[DATA_W-1]); // R8
    AST_CPU_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == STAT_A && !per_stat_wr) |=> $stable(stat_word)); // R5

endmodule

// File: tb/test_spi_mailbox_ram.sv
`timescale 1ns/1ps
module test_spi_mailbox_ram;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_we, per_we;
    logic [5:0]  cpu_addr, per_addr;
    logic [31:0] cpu_wdata, per_wdata, cpu_rdata, per_rdata;
    logic        start_pulse;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_mem [64];
    logic        exp_busy;
    logic [7:0]  exp_rx;

    always #10 clk = ~clk;

    spi_mailbox_ram i_spi_mailbox_ram (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .start_pulse(start_pulse)
    );

    function automatic logic [31:0] pat(int a);
        return (32'(a) * 32'h01F3_A5C7) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] expw(int a);
        if (a == 61) return {exp_busy, 23'b0, exp_rx};
        return exp_mem[a];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_we = 0; per_we = 0; cpu_wdata = '0; per_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 0; idle(); cpu_addr = 0; per_addr = 0;
        exp_busy = 0; exp_rx = 0;
        repeat (3) step();
        chk("R10 start in reset", 32'(start_pulse), 0);
        rst_n = 1;
        per_addr = 61; step();
        chk("R10 status after reset", per_rdata, 0);

        // R1: processor writes every address
        for (int a = 0; a < 64; a++) begin
            cpu_we = 1; cpu_addr = 6'(a); cpu_wdata = pat(a);
            if (a != 61) exp_mem[a] = pat(a);
            if (a == 60) exp_busy = 1;
            step();
            chk("R7 start after write", 32'(start_pulse), 32'(a == 60));
        end
        idle();
        for (int a = 0; a < 64; a++) begin
            cpu_addr = 6'(a); per_addr = 6'(63 - a); step();
            chk("R1 cpu read", cpu_rdata, expw(a));
            chk("R2 per read", per_rdata, expw(63 - a));
        end

        // R3/R4: peripheral writes elsewhere are dropped
        for (int a = 0; a < 64; a++) begin
            if (a == 61) continue;
            per_we = 1; per_addr = 6'(a); per_wdata = ~pat(a); step();
        end
        idle();
        for (int a = 0; a < 64; a++) begin
            cpu_addr = 6'(a); per_addr = 6'(a); step();
            chk(a == 60 ? "R3 cfg kept (cpu)" : "R4 word kept (cpu)", cpu_rdata, expw(a));
            chk(a == 60 ? "R3 cfg readable by per" : "R4 word kept (per)", per_rdata, expw(a));
        end

        // R6: status format
        per_we = 1; per_addr = 61; per_wdata = 32'hFFFF_FFFF; step();
        idle(); step();
        chk("R6 status mask", per_rdata, 32'h8000_00FF);
        per_we = 1; per_wdata = 32'h7FFF_FF5A; step();
        idle(); step();
        chk("R6 busy clear", per_rdata, 32'h0000_005A);

        // R5: processor cannot write status
        cpu_we = 1; cpu_addr = 61; cpu_wdata = 32'hFFFF_FFFF; step();
        idle(); step();
        chk("R5 status unchanged", cpu_rdata, 32'h0000_005A);
        chk("R5 no start", 32'(start_pulse), 0);

        // R8: busy visible on the poll right after the config write
        cpu_we = 1; cpu_addr = 60; cpu_wdata = 32'h0012_3456; per_addr = 61; step();
        chk("R7 start high", 32'(start_pulse), 1);
        chk("R2 read-first status", per_rdata, 32'h0000_005A);
        idle(); step();
        chk("R7 start one cycle", 32'(start_pulse), 0);
        chk("R8 busy on poll", per_rdata, 32'h8000_005A);
        per_addr = 60; step();
        chk("R3 per reads cfg", per_rdata, 32'h0012_3456);

        // R9: collision of status write and config write
        per_we = 1; per_addr = 61; per_wdata = 32'h0000_00C3;
        cpu_we = 1; cpu_addr = 60; cpu_wdata = 32'h0000_0011; step();
        idle(); step();
        chk("R9 collision", per_rdata, 32'h8000_00C3);

        // R7: back-to-back starts
        cpu_we = 1; cpu_addr = 60; step();
        chk("R7 b2b first", 32'(start_pulse), 1);
        step();
        chk("R7 b2b second", 32'(start_pulse), 1);
        idle(); step();
        chk("R7 b2b end", 32'(start_pulse), 0);

        // R2: read-first on general storage
        cpu_we = 1; cpu_addr = 5; cpu_wdata = 32'hDEAD_BEEF; per_addr = 5; step();
        chk("R2 old data same cycle", per_rdata, pat(5));
        idle(); step();
        chk("R2 new data next cycle", per_rdata, 32'hDEAD_BEEF);

        // R10: reset mid-run clears status and start
        cpu_we = 1; cpu_addr = 60; step();
        idle(); #3 rst_n = 0; #2;
        chk("R10 start cleared", 32'(start_pulse), 0);
        step(); rst_n = 1;
        per_addr = 61; step();
        chk("R10 status cleared", per_rdata, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule